// File: doc/BRIEF.md
# Byte-Lane Access Qualifier for a Two-Region Bus Target

This block is placed behind the data-phase logic of a 32-bit bus target. It serves two internal back ends: a bulk memory region and a control-register region. For each data phase it receives five things: the region select, the direction, an active-low byte-enable nibble, the word address and the write data. It then decides whether the phase reaches a back end or is dropped on the inside. The bus transfer itself always completes, so a dropped phase is invisible on the bus except through the data returned.

The lane rules differ by region and by direction. Memory writes must cover a half word or a full word. Memory reads ignore the lanes. Register writes must cover all four lanes. Register reads need a half word or a full word, and otherwise return zeros without touching the register file. Register reads are not allowed to burst. When a register read is the start of a longer transfer, the block asks the bus side to disconnect, and it refuses any further register-read phases. Each phase produces exactly one outcome pulse, either a forward strobe or a discard pulse. This pulse appears one clock after the phase is presented.

Top module: `baq_access_qualifier`

## Requirements
- R1: A memory-region write with byte enables 4'b0011, 4'b1100 or 4'b0000 (bit n low means lane n active) raises mem_wr_stb for one cycle, one clock after the phase, with out_addr and out_wdata equal to the phase's address and data. Any other pattern raises no write strobe.
- R2: On a forwarded memory write, mem_wmask is the bitwise inverse of the byte enables (4'b0011 gives 4'b1100). In every other cycle it is zero.
- R3: A memory-region read raises mem_rd_stb whatever the byte enables are. In the same cycle, rd_valid is high and rd_data equals mem_rdata.
- R4: A register-region write raises reg_wr_stb only for byte enables 4'b0000. Any other pattern is dropped.
- R5: A register-region read that is the first phase, with byte enables 4'b0011, 4'b1100 or 4'b0000, raises reg_rd_stb. In the same cycle, rd_valid is high and rd_data equals reg_rdata.
- R6: A register-region read with any other lane pattern raises no read strobe. It still returns rd_valid, with rd_data equal to zero.
- R7: Every accepted phase gives exactly one strobe, and every rejected phase gives exactly one discard_pulse, one clock after the phase. At most one of the five outcome pulses is high in any cycle, and rd_data is zero whenever rd_valid is low.
- R8: A register-region read phase that is not the first of its transfer (ph_first low) is rejected: there is no strobe, rd_data is zero and discard_pulse is raised.
- R9: A register-region read that is the first phase and has ph_last low raises disconnect_req in the cycle its result appears. No other phase raises it.
- R10: Burst writes to both regions and burst reads from memory are accepted on non-first phases under the same lane rules as single phases.
- R11: After reset, and in cycles with no phase, every strobe, pulse and rd_valid output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ph_valid | input | 1 | A data phase is presented this cycle |
| ph_region | input | 1 | 0 selects the memory region, 1 the register region |
| ph_write | input | 1 | 1 for a write, 0 for a read |
| ph_first | input | 1 | This is the first data phase of its transfer |
| ph_last | input | 1 | No further data phases follow in this transfer |
| ph_be_n | input | 4 | Active-low byte enables |
| ph_addr | input | 32 | Word address of the phase |
| ph_wdata | input | 32 | Write data |
| mem_rdata | input | 32 | Memory back-end read data, valid while mem_rd_stb is high |
| reg_rdata | input | 32 | Register back-end read data, valid while reg_rd_stb is high |
| mem_wr_stb | output | 1 | Memory write strobe |
| mem_rd_stb | output | 1 | Memory read strobe |
| mem_wmask | output | 4 | Active-high byte write mask for memory |
| reg_wr_stb | output | 1 | Register write strobe |
| reg_rd_stb | output | 1 | Register read strobe |
| out_addr | output | 32 | Address toward both back ends |
| out_wdata | output | 32 | Write data toward both back ends |
| rd_valid | output | 1 | Read response for the phase is on rd_data |
| rd_data | output | 32 | Read response, zero when the read was refused |
| discard_pulse | output | 1 | The phase was dropped internally |
| disconnect_req | output | 1 | Ask the bus side to end a register-read burst |

## Verification
The hardest case to reach is the pair of refusals on register reads. In the first, a continuation phase has valid lanes but is still refused. In the second, a first phase with the burst flag set must both be served and request a disconnect. Uniform random stimulus seldom produces these combinations together with a given lane pattern. So the stimulus draws the byte enables half from the three legal patterns and half from all sixteen values, and it draws ph_first and ph_last independently. Directed phases then cover each refusal with every legal pattern.

// File: rtl/baq_pkg.sv
package baq_pkg;
   typedef enum logic [1:0] {
      LP_LOW_HALF  = 2'd0,
      LP_HIGH_HALF = 2'd1,
      LP_FULL      = 2'd2,
      LP_ILLEGAL   = 2'd3
   } lane_pat_e;

   typedef struct packed {
      logic mem_wr;
      logic mem_rd;
      logic reg_wr;
      logic reg_rd;
      logic drop;
      logic rd_resp;
      logic disc;
   } verdict_t;

   localparam logic REGION_MEM = 1'b0;
   localparam logic REGION_REG = 1'b1;
endpackage

// File: rtl/baq_lane_decode.sv
module baq_lane_decode
   import baq_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic [LANES-1:0] be_n,
   output lane_pat_e        pat,
   output logic [LANES-1:0] lane_act
);
   localparam int HALF = LANES / 2;

   logic [LANES-1:0] low_half_mask;
   logic [LANES-1:0] high_half_mask;

   generate
      if (LANES % 2 != 0 || LANES < 2) begin : g_bad_lanes
         $error("baq_lane_decode: LANES must be even and at least 2");
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane_act[i]       = ~be_n[i];
         assign low_half_mask[i]  = (i < HALF);
         assign high_half_mask[i] = (i >= HALF);
      end
   endgenerate

   always_comb begin
      if (lane_act == {LANES{1'b1}})
         pat = LP_FULL;
      else if (lane_act == low_half_mask)
         pat = LP_LOW_HALF;
      else if (lane_act == high_half_mask)
         pat = LP_HIGH_HALF;
      else
         pat = LP_ILLEGAL;
   end
endmodule

// File: rtl/baq_policy.sv
module baq_policy
   import baq_pkg::*;
#(
   parameter bit REG_BURST_RD = 1'b0
) (
   input  logic      valid,
   input  logic      region,
   input  logic      write,
   input  logic      first,
   input  logic      last,
   input  lane_pat_e pat,
   output verdict_t  verdict
);
   logic half_or_full;
   logic full_only;
   logic reg_rd_phase_ok;
   logic reg_rd_burst_start;

   assign half_or_full = (pat != LP_ILLEGAL);
   assign full_only    = (pat == LP_FULL);

   generate
      if (REG_BURST_RD) begin : g_reg_burst_ok
         assign reg_rd_phase_ok    = 1'b1;
         assign reg_rd_burst_start = 1'b0;
      end else begin : g_reg_single_only
         assign reg_rd_phase_ok    = first;
         assign reg_rd_burst_start = first & ~last;
      end
   endgenerate

   always_comb begin
      verdict = '0;
      if (valid) begin
         if (region == REGION_MEM) begin
            if (write) begin
               verdict.mem_wr = half_or_full;
               verdict.drop   = ~half_or_full;
            end else begin
               verdict.mem_rd  = 1'b1;
               verdict.rd_resp = 1'b1;
            end
         end else begin
            if (write) begin
               verdict.reg_wr = full_only;
               verdict.drop   = ~full_only;
            end else begin
               verdict.reg_rd  = half_or_full & reg_rd_phase_ok;
               verdict.drop    = ~(half_or_full & reg_rd_phase_ok);
               verdict.rd_resp = 1'b1;
               verdict.disc    = reg_rd_burst_start;
            end
         end
      end
   end
endmodule

// File: rtl/baq_datapath.sv
module baq_datapath
   import baq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LANES  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  verdict_t          verdict,
   input  logic [LANES-1:0]  lane_act,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] reg_rdata,
   output verdict_t          verdict_q,
   output logic [LANES-1:0]  wmask,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         verdict_q <= '0;
         wmask     <= '0;
         addr_q    <= '0;
         wdata_q   <= '0;
      end else begin
         verdict_q <= verdict;
         wmask     <= verdict.mem_wr ? lane_act : '0;
         addr_q    <= addr_in;
         wdata_q   <= wdata_in;
      end
   end

   always_comb begin
      if (verdict_q.mem_rd)
         rd_data = mem_rdata;
      else if (verdict_q.reg_rd)
         rd_data = reg_rdata;
      else
         rd_data = '0;
   end

   // R6
   refused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_q.rd_resp && !verdict_q.mem_rd && !verdict_q.reg_rd) |-> (rd_data == '0));

   // R2
   mask_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !verdict_q.mem_wr |-> (wmask == '0));
endmodule

// File: rtl/baq_access_qualifier.sv
module baq_access_qualifier
   import baq_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter bit REG_BURST_RD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ph_valid,
   input  logic              ph_region,
   input  logic              ph_write,
   input  logic              ph_first,
   input  logic              ph_last,
   input  logic [3:0]        ph_be_n,
   input  logic [ADDR_W-1:0] ph_addr,
   input  logic [DATA_W-1:0] ph_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              mem_wr_stb,
   output logic              mem_rd_stb,
   output logic [3:0]        mem_wmask,
   output logic              reg_wr_stb,
   output logic              reg_rd_stb,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              discard_pulse,
   output logic              disconnect_req
);
   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("baq_access_qualifier: only a 32-bit data path is supported");
      end
      if (ADDR_W != 32) begin : g_bad_addr
         $error("baq_access_qualifier: only 32-bit addressing is supported");
      end
   endgenerate

   lane_pat_e        pat;
   logic [LANES-1:0] lane_act;
   verdict_t         verdict;
   verdict_t         verdict_q;

   baq_lane_decode #(.LANES(LANES)) u_decode (
      .be_n     (ph_be_n),
      .pat      (pat),
      .lane_act (lane_act)
   );

   baq_policy #(.REG_BURST_RD(REG_BURST_RD)) u_policy (
      .valid   (ph_valid),
      .region  (ph_region),
      .write   (ph_write),
      .first   (ph_first),
      .last    (ph_last),
      .pat     (pat),
      .verdict (verdict)
   );

   baq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .verdict   (verdict),
      .lane_act  (lane_act),
      .addr_in   (ph_addr),
      .wdata_in  (ph_wdata),
      .mem_rdata (mem_rdata),
      .reg_rdata (reg_rdata),
      .verdict_q (verdict_q),
      .wmask     (mem_wmask),
      .addr_q    (out_addr),
      .wdata_q   (out_wdata),
      .rd_data   (rd_data)
   );

   assign mem_wr_stb     = verdict_q.mem_wr;
   assign mem_rd_stb     = verdict_q.mem_rd;
   assign reg_wr_stb     = verdict_q.reg_wr;
   assign reg_rd_stb     = verdict_q.reg_rd;
   assign discard_pulse  = verdict_q.drop;
   assign rd_valid       = verdict_q.rd_resp;
   assign disconnect_req = verdict_q.disc;

   // R7
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_wr_stb, mem_rd_stb, reg_wr_stb, reg_rd_stb, discard_pulse}));

   // R7
   phase_has_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_valid |=> $countones({mem_wr_stb, mem_rd_stb, reg_wr_stb, reg_rd_stb, discard_pulse}) == 1);

   // R4
   reg_wr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_valid && ph_region && ph_write && ph_be_n != 4'b0000) |=> (!reg_wr_stb && discard_pulse));

   // R1
   mem_wr_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_stb |-> (mem_wmask == 4'b1100 || mem_wmask == 4'b0011 || mem_wmask == 4'b1111));

   // R9
   disconnect_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disconnect_req |-> (rd_valid && !mem_rd_stb));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ph_valid |=> !(rd_valid || discard_pulse || disconnect_req || mem_wr_stb || reg_wr_stb));
endmodule

// File: tb/baq_access_qualifier_bench.sv
module baq_access_qualifier_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ph_valid = 1'b0, ph_region = 1'b0, ph_write = 1'b0;
   logic        ph_first = 1'b1, ph_last = 1'b1;
   logic [3:0]  ph_be_n = 4'hF;
   logic [31:0] ph_addr = '0, ph_wdata = '0;
   logic [31:0] mem_rdata, reg_rdata;
   logic        mem_wr_stb, mem_rd_stb, reg_wr_stb, reg_rd_stb;
   logic [3:0]  mem_wmask;
   logic [31:0] out_addr, out_wdata, rd_data;
   logic        rd_valid, discard_pulse, disconnect_req;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // back-end models
   assign mem_rdata = {out_addr[15:0], 16'hA5C3} ^ 32'h0F0F_1234;
   assign reg_rdata = ~out_addr + 32'h55;

   baq_access_qualifier u_baq_access_qualifier (
      .clk(clk), .rst_n(rst_n), .ph_valid(ph_valid), .ph_region(ph_region),
      .ph_write(ph_write), .ph_first(ph_first), .ph_last(ph_last),
      .ph_be_n(ph_be_n), .ph_addr(ph_addr), .ph_wdata(ph_wdata),
      .mem_rdata(mem_rdata), .reg_rdata(reg_rdata),
      .mem_wr_stb(mem_wr_stb), .mem_rd_stb(mem_rd_stb), .mem_wmask(mem_wmask),
      .reg_wr_stb(reg_wr_stb), .reg_rd_stb(reg_rd_stb), .out_addr(out_addr),
      .out_wdata(out_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .discard_pulse(discard_pulse), .disconnect_req(disconnect_req)
   );

   typedef struct packed {
      logic       mwr, mrd, rwr, rrd, drop, rv, disc;
      logic [3:0] mask;
   } exp_t;

   function automatic logic legal_half(input logic [3:0] be);
      return (be == 4'b0011) || (be == 4'b1100) || (be == 4'b0000);
   endfunction

   function automatic exp_t predict(input logic v, input logic rg, input logic wr,
                                    input logic fi, input logic la, input logic [3:0] be);
      exp_t e = '0;
      if (v) begin
         if (!rg && wr) begin
            e.mwr = legal_half(be); e.drop = !legal_half(be);
            e.mask = legal_half(be) ? ~be : 4'b0000;
         end else if (!rg) begin
            e.mrd = 1'b1; e.rv = 1'b1;
         end else if (wr) begin
            e.rwr = (be == 4'b0000); e.drop = (be != 4'b0000);
         end else begin
            e.rrd = legal_half(be) && fi; e.drop = !(legal_half(be) && fi);
            e.rv = 1'b1; e.disc = fi && !la;
         end
      end
      return e;
   endfunction

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
      end
   endtask

   // drives one phase at a negedge and checks its result at the next negedge
   task automatic phase(input logic v, input logic rg, input logic wr, input logic fi,
                        input logic la, input logic [3:0] be, input logic [31:0] a,
                        input logic [31:0] d);
      exp_t e;
      logic [31:0] exp_rd;
      ph_valid = v; ph_region = rg; ph_write = wr; ph_first = fi; ph_last = la;
      ph_be_n = be; ph_addr = a; ph_wdata = d;
      e = predict(v, rg, wr, fi, la, be);
      @(negedge clk);
      exp_rd = e.mrd ? ({a[15:0], 16'hA5C3} ^ 32'h0F0F_1234) :
               e.rrd ? (~a + 32'h55) : 32'h0;
      chk(mem_wr_stb == e.mwr, "R1 mem_wr_stb", {31'b0, mem_wr_stb}, {31'b0, e.mwr});
      chk(mem_wmask == e.mask, "R2 mem_wmask", {28'b0, mem_wmask}, {28'b0, e.mask});
      chk(mem_rd_stb == e.mrd, "R3 mem_rd_stb", {31'b0, mem_rd_stb}, {31'b0, e.mrd});
      chk(reg_wr_stb == e.rwr, "R4 reg_wr_stb", {31'b0, reg_wr_stb}, {31'b0, e.rwr});
      chk(reg_rd_stb == e.rrd, "R5/R8 reg_rd_stb", {31'b0, reg_rd_stb}, {31'b0, e.rrd});
      chk(rd_valid == e.rv, "R6 rd_valid", {31'b0, rd_valid}, {31'b0, e.rv});
      chk(rd_data == exp_rd, "R6/R7 rd_data", rd_data, exp_rd);
      chk(discard_pulse == e.drop, "R7 discard_pulse", {31'b0, discard_pulse}, {31'b0, e.drop});
      chk(disconnect_req == e.disc, "R9 disconnect_req", {31'b0, disconnect_req}, {31'b0, e.disc});
      if (e.mwr || e.rwr) begin
         chk(out_addr == a, "R1 out_addr", out_addr, a);
         chk(out_wdata == d, "R1 out_wdata", out_wdata, d);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      logic [3:0] legal [3];
      int unsigned seed_dummy;
      legal[0] = 4'b0011; legal[1] = 4'b1100; legal[2] = 4'b0000;
      seed_dummy = $urandom(32'd1553);
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!(mem_wr_stb | mem_rd_stb | reg_wr_stb | reg_rd_stb | rd_valid | discard_pulse | disconnect_req),
          "R11 reset quiet", 32'h1, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1/R2 directed memory writes, all 16 patterns
      for (int b = 0; b < 16; b++) phase(1, 0, 1, 1, 1, 4'(b), 32'h100 + 32'(b), 32'hCAFE_0000 + 32'(b));
      // R4 register writes, all 16 patterns
      for (int b = 0; b < 16; b++) phase(1, 1, 1, 1, 1, 4'(b), 32'h200 + 32'(b), 32'h1234_0000 + 32'(b));
      // R3 memory reads ignore lanes
      for (int b = 0; b < 16; b++) phase(1, 0, 0, 1, 1, 4'(b), 32'h300 + 32'(b), 32'h0);
      // R5/R6 register reads, single phase
      for (int b = 0; b < 16; b++) phase(1, 1, 0, 1, 1, 4'(b), 32'h400 + 32'(b), 32'h0);
      // R8/R9 register read burst: first served with disconnect, continuation refused
      for (int k = 0; k < 3; k++) begin
         phase(1, 1, 0, 1, 0, legal[k], 32'h500, 32'h0);
         phase(1, 1, 0, 0, 0, legal[k], 32'h504, 32'h0);
         phase(1, 1, 0, 0, 1, legal[k], 32'h508, 32'h0);
      end
      // R10 bursts of writes and memory reads
      phase(1, 0, 1, 1, 0, 4'b0000, 32'h600, 32'h1);
      phase(1, 0, 1, 0, 0, 4'b1100, 32'h604, 32'h2);
      phase(1, 0, 1, 0, 1, 4'b0011, 32'h608, 32'h3);
      phase(1, 1, 1, 1, 0, 4'b0000, 32'h700, 32'h4);
      phase(1, 1, 1, 0, 1, 4'b0000, 32'h704, 32'h5);
      phase(1, 0, 0, 1, 0, 4'b0110, 32'h800, 32'h0);
      phase(1, 0, 0, 0, 1, 4'b1111, 32'h804, 32'h0);
      // R11 idle cycles
      phase(0, 1, 0, 1, 0, 4'b0000, 32'h900, 32'h0);
      phase(0, 0, 1, 1, 1, 4'b0000, 32'h904, 32'h0);
      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         logic [3:0] be;
         be = ($urandom % 2 == 0) ? legal[$urandom % 3] : 4'($urandom);
         phase(($urandom % 8) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), be, $urandom, $urandom);
      end
      phase(0, 0, 0, 1, 1, 4'hF, 32'h0, 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule